// File: doc/BRIEF.md
# Three-Level Short-Vector Redundancy Selector

In a three-level neutral-point-clamped three-phase inverter, each of the six short space vectors can be made by two switching states. One state (the "low" member) ties phases to the lower rail. The other (the "high" member) ties phases to the upper rail. Both members give the same line-to-line voltages, but they push the neutral-point current in opposite directions. This block picks one member of the pair on every clock, so that the dc-link capacitor voltages are pulled back toward balance.

The modulator upstream supplies a short-vector index, the signed capacitor imbalance and the current sign of each phase. The block returns the per-phase switching state triple and the sign of the neutral-point current that the chosen state is expected to draw. Sector and region detection, dwell times and sequence timing stay with the modulator. A programmable deadband around zero imbalance keeps the last choice, so that small errors cause no extra switching.

Top module: `npc_short_vec_sel`

## Requirements
- R1: While `rst_n` is low, all state outputs and `np_sgn` are 0, and the held choice is the low member.
- R2: Every 2-bit value is two's complement: 01 is +1, 00 is 0, 11 is -1. The low members for indices 1 to 6 are (a,b,c) = (0,-1,-1), (0,0,-1), (-1,0,-1), (-1,0,0), (-1,-1,0) and (0,-1,0). For a valid index the output is always the low or the high member of that index.
- R3: The high member of an index is its low member with +1 added to every phase.
- R4: `np_sgn` is the sign of the sum of the current signs of the phases whose chosen state is 0. A current code of 10 counts as 0.
- R5: When `cap_err` > `deadband`, the member with the smaller neutral-point sign is chosen. When `cap_err` < -`deadband`, the member with the larger sign is chosen. If the two signs are equal, the held choice is kept.
- R6: When |`cap_err`| <= `deadband`, the held low/high choice is kept, including when the index changes.
- R7: An index of 0 or 7 drives all states and `np_sgn` to 0 and leaves the held choice unchanged.
- R8: Outputs reflect the inputs of the previous clock edge (one register stage).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vec_idx | input | 3 | Short-vector index, 1 to 6 valid |
| cap_err | input | EW | Signed capacitor imbalance, upper minus lower |
| deadband | input | EW-1 | Unsigned hold band around zero imbalance |
| ia_sgn | input | 2 | Phase a current sign |
| ib_sgn | input | 2 | Phase b current sign |
| ic_sgn | input | 2 | Phase c current sign |
| st_a | output | 2 | Phase a state |
| st_b | output | 2 | Phase b state |
| st_c | output | 2 | Phase c state |
| np_sgn | output | 2 | Expected neutral-point current sign |

## Verification
The bench builds the block with EW = 8. With an error this narrow, random imbalance values often land exactly on the deadband edges, both inside and just outside. The deadband itself is driven from 0 up to 20. A value of 0 makes the hold rule depend only on an exact zero error. Larger values keep the held choice alive across runs of index changes. That way the hold path, the tie path and the steering path are all exercised often.

// File: rtl/npc_short_vec_sel.sv
module npc_short_vec_sel #(
  parameter int EW = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           vec_idx,
  input  logic signed [EW-1:0] cap_err,
  input  logic [EW-2:0]        deadband,
  input  logic [1:0]           ia_sgn,
  input  logic [1:0]           ib_sgn,
  input  logic [1:0]           ic_sgn,
  output logic [1:0]           st_a,
  output logic [1:0]           st_b,
  output logic [1:0]           st_c,
  output logic [1:0]           np_sgn
);

  function automatic logic [5:0] low_of(input logic [2:0] k);
    case (k)
      3'd1:    low_of = {2'b00, 2'b11, 2'b11};
      3'd2:    low_of = {2'b00, 2'b00, 2'b11};
      3'd3:    low_of = {2'b11, 2'b00, 2'b11};
      3'd4:    low_of = {2'b11, 2'b00, 2'b00};
      3'd5:    low_of = {2'b11, 2'b11, 2'b00};
      3'd6:    low_of = {2'b00, 2'b11, 2'b00};
      default: low_of = 6'd0;
    endcase
  endfunction

  function automatic logic [1:0] bump(input logic [1:0] s);
    bump = (s == 2'b11) ? 2'b00 : 2'b01;
  endfunction

  function automatic logic signed [2:0] cur(input logic [1:0] c);
    case (c)
      2'b01:   cur = 3'sd1;
      2'b11:   cur = -3'sd1;
      default: cur = 3'sd0;
    endcase
  endfunction

  function automatic logic signed [1:0] np_of(input logic [5:0] v,
                                              input logic [1:0] ca,
                                              input logic [1:0] cb,
                                              input logic [1:0] cc);
    logic signed [2:0] acc;
    acc = 3'sd0;
    if (v[5:4] == 2'b00) acc = acc + cur(ca);
    if (v[3:2] == 2'b00) acc = acc + cur(cb);
    if (v[1:0] == 2'b00) acc = acc + cur(cc);
    np_of = (acc > 3'sd0) ? 2'sb01 : (acc < 3'sd0) ? 2'sb11 : 2'sb00;
  endfunction

  logic              idx_ok, hold_hi, pick_hi, above, below;
  logic [5:0]        lo_v, hi_v, ch_v;
  logic signed [1:0] s_lo, s_hi;
  logic signed [EW:0] err_x, db_x;

  assign idx_ok = (vec_idx >= 3'd1) && (vec_idx <= 3'd6);
  assign lo_v   = low_of(vec_idx);
  assign hi_v   = {bump(lo_v[5:4]), bump(lo_v[3:2]), bump(lo_v[1:0])};
  assign s_lo   = np_of(lo_v, ia_sgn, ib_sgn, ic_sgn);
  assign s_hi   = np_of(hi_v, ia_sgn, ib_sgn, ic_sgn);
  assign err_x  = {cap_err[EW-1], cap_err};
  assign db_x   = {2'b00, deadband};
  assign above  = err_x > db_x;
  assign below  = err_x < -db_x;

  always_comb begin
    pick_hi = hold_hi;
    if (above && s_hi != s_lo) pick_hi = s_hi < s_lo;
    else if (below && s_hi != s_lo) pick_hi = s_hi > s_lo;
  end

  assign ch_v = pick_hi ? hi_v : lo_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_hi <= 1'b0;
      st_a    <= 2'b00;
      st_b    <= 2'b00;
      st_c    <= 2'b00;
      np_sgn  <= 2'b00;
    end else if (idx_ok) begin
      hold_hi <= pick_hi;
      st_a    <= ch_v[5:4];
      st_b    <= ch_v[3:2];
      st_c    <= ch_v[1:0];
      np_sgn  <= pick_hi ? s_hi : s_lo;
    end else begin
      st_a    <= 2'b00;
      st_b    <= 2'b00;
      st_c    <= 2'b00;
      np_sgn  <= 2'b00;
    end
  end

endmodule

// File: rtl/npc_short_vec_sel_chk.sv
module npc_short_vec_sel_chk #(
  parameter int EW = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [2:0]           vec_idx,
  input logic signed [EW-1:0] cap_err,
  input logic [EW-2:0]        deadband,
  input logic [1:0]           ia_sgn,
  input logic [1:0]           ib_sgn,
  input logic [1:0]           ic_sgn,
  input logic [1:0]           st_a,
  input logic [1:0]           st_b,
  input logic [1:0]           st_c,
  input logic [1:0]           np_sgn
);

  logic valid_in, in_band, has_pos, has_neg, all_zero;
  logic signed [EW:0] mag;

  assign valid_in = (vec_idx != 3'd0) && (vec_idx != 3'd7);
  assign mag      = cap_err[EW-1] ? -{cap_err[EW-1], cap_err} : {1'b0, cap_err};
  assign in_band  = mag <= $signed({2'b00, deadband});
  assign has_pos  = (st_a == 2'b01) || (st_b == 2'b01) || (st_c == 2'b01);
  assign has_neg  = (st_a == 2'b11) || (st_b == 2'b11) || (st_c == 2'b11);
  assign all_zero = (st_a == 2'b00) && (st_b == 2'b00) && (st_c == 2'b00);

  assert_legal_codes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_a != 2'b10) && (st_b != 2'b10) && (st_c != 2'b10) && (np_sgn != 2'b10));

  assert_short_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |=> (!all_zero && !(has_pos && has_neg)));

  assert_invalid_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> (all_zero && np_sgn == 2'b00));

  assert_band_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && in_band && has_pos) |=> has_pos);

  assert_band_hold_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && in_band && has_neg) |=> has_neg);

endmodule

bind npc_short_vec_sel npc_short_vec_sel_chk #(.EW(EW)) u_chk (.*);

// File: tb/tb_npc_short_vec_sel.sv
module tb_npc_short_vec_sel;
  localparam int EW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] vec_idx = 3'd0;
  logic signed [EW-1:0] cap_err = '0;
  logic [EW-2:0] deadband = '0;
  logic [1:0] ia_sgn = 2'b00, ib_sgn = 2'b00, ic_sgn = 2'b00;
  logic [1:0] st_a, st_b, st_c, np_sgn;

  int vectors = 0, fails = 0;
  logic m_hi = 1'b0;
  logic [7:0] exp_o;
  string exp_tag;

  always #4 clk = ~clk;

  npc_short_vec_sel #(.EW(EW)) dut (.*);

  function automatic logic [5:0] lo_ref(input logic [2:0] k);
    case (k)
      3'd1: return {2'b00, 2'b11, 2'b11};
      3'd2: return {2'b00, 2'b00, 2'b11};
      3'd3: return {2'b11, 2'b00, 2'b11};
      3'd4: return {2'b11, 2'b00, 2'b00};
      3'd5: return {2'b11, 2'b11, 2'b00};
      3'd6: return {2'b00, 2'b11, 2'b00};
      default: return 6'd0;
    endcase
  endfunction

  function automatic int val(input logic [1:0] c);
    return (c == 2'b01) ? 1 : (c == 2'b11) ? -1 : 0;
  endfunction

  function automatic logic [1:0] enc(input int v);
    return (v > 0) ? 2'b01 : (v < 0) ? 2'b11 : 2'b00;
  endfunction

  function automatic int npv(input logic [5:0] s, input logic [1:0] a,
                             input logic [1:0] b, input logic [1:0] c);
    int t;
    t = 0;
    if (s[5:4] == 2'b00) t += val(a);
    if (s[3:2] == 2'b00) t += val(b);
    if (s[1:0] == 2'b00) t += val(c);
    return (t > 0) ? 1 : (t < 0) ? -1 : 0;
  endfunction

  task automatic model;
    logic [5:0] lo, hi;
    int sl, sh, e, d;
    logic ph;
    lo = lo_ref(vec_idx);
    if (lo == 6'd0) begin
      exp_o = 8'd0;
      exp_tag = "R7";
      return;
    end
    hi = {enc(val(lo[5:4]) + 1), enc(val(lo[3:2]) + 1), enc(val(lo[1:0]) + 1)};
    sl = npv(lo, ia_sgn, ib_sgn, ic_sgn);
    sh = npv(hi, ia_sgn, ib_sgn, ic_sgn);
    e = int'(cap_err);
    d = int'(deadband);
    ph = m_hi;
    if (e > d && sl != sh) ph = (sh < sl);
    else if (e < -d && sl != sh) ph = (sh > sl);
    exp_tag = (e > d || e < -d) ? "R5 R4 R3 R2" : "R6 R4 R3 R2";
    m_hi = ph;
    exp_o = ph ? {hi, enc(sh)} : {lo, enc(sl)};
  endtask

  task automatic apply(input logic [2:0] k, input int e, input int d,
                       input logic [1:0] a, input logic [1:0] b, input logic [1:0] c);
    vec_idx = k;
    cap_err = EW'(e);
    deadband = (EW-1)'(d);
    ia_sgn = a;
    ib_sgn = b;
    ic_sgn = c;
    model();
    @(negedge clk);
    vectors++;
    if ({st_a, st_b, st_c, np_sgn} !== exp_o) begin
      fails++;
      $display("FAIL %s R8: idx=%0d got %b expected %b", exp_tag, k,
               {st_a, st_b, st_c, np_sgn}, exp_o);
    end
  endtask

  function automatic logic [1:0] rcur();
    case ($urandom_range(0, 2))
      0: return 2'b11;
      1: return 2'b00;
      default: return 2'b01;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    vec_idx = 3'd1;
    cap_err = 8'sd50;
    repeat (3) @(negedge clk);
    vectors++;
    if ({st_a, st_b, st_c, np_sgn} !== 8'd0) begin
      fails++;
      $display("FAIL R1: got %b expected %b", {st_a, st_b, st_c, np_sgn}, 8'd0);
    end
    rst_n = 1'b1;
    // R1: in-band after reset keeps the low member
    apply(3'd2, 0, 5, 2'b01, 2'b01, 2'b11);
    // R5: example pair, ia positive, ib/ic negative, positive error picks high
    apply(3'd1, 20, 4, 2'b01, 2'b11, 2'b11);
    // R6: index change inside band keeps high
    apply(3'd4, 4, 4, 2'b11, 2'b01, 2'b01);
    apply(3'd5, -4, 4, 2'b01, 2'b01, 2'b01);
    // R5: boundary just outside band, negative
    apply(3'd1, -5, 4, 2'b01, 2'b11, 2'b11);
    // R5: equal signs keep previous
    apply(3'd3, 30, 2, 2'b00, 2'b00, 2'b00);
    // R7: invalid indices leave the held choice
    apply(3'd0, 40, 2, 2'b01, 2'b01, 2'b01);
    apply(3'd7, -40, 2, 2'b01, 2'b11, 2'b01);
    apply(3'd6, 0, 0, 2'b10, 2'b01, 2'b11);
    // R4: code 10 counts as zero
    apply(3'd2, 9, 0, 2'b10, 2'b10, 2'b01);
    for (int n = 0; n < 3000; n++) begin
      int d, e;
      d = $urandom_range(0, 20);
      case ($urandom_range(0, 3))
        0: e = d;
        1: e = -d - 1;
        2: e = d + 1;
        default: e = $urandom_range(0, 255) - 128;
      endcase
      apply(3'($urandom_range(0, 7)), e, d, rcur(), rcur(), rcur());
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule